// File: doc/BRIEF.md
# Mixed-Width Host Data Port

This block connects a host bus of 16 or 32 bits to a byte-wide packet buffer. The buffer is reached through an internal pointer that steps forward on its own. The port contains two one-way byte queues of twelve entries each. Bytes the host writes go into the outbound queue, and a memory sequencer stores them one per clock at the pointer. In read direction the sequencer fetches buffer bytes ahead of demand into the inbound queue, so a host read finishes as soon as enough bytes are waiting.

Every host access moves one, two, three or four bytes. The count comes from the active-low byte enables, together with address bit 1 for a 16-bit host placed on the upper word. Accesses of any width can follow one another in any order. Each access takes the next bytes of the stream, whatever the pointer alignment. Loading a new pointer with a direction bit first drains any pending outbound bytes at the old pointer. It then discards stale read-ahead data and, in read direction, starts fetching again from the new address. The buffer is modelled as a synchronous single-port RAM inside the block.

Top module: `hdp_port`

## Requirements
- R1: After reset the pointer is 0, the direction is write and both queues are empty. A read of one or more bytes stalls (`host_rdy` low) and a write of up to twelve bytes is ready at once. `host_rdy` is low whenever `host_sel` is low.
- R2: Bit i of `host_be_n` enables lane i, which is data bits 8i+7..8i. With `host_a1`=0 the active lanes are the inverse of `host_be_n`. With `host_a1`=1 they are lanes 2 and 3, enabled by the inverse of `host_be_n[1:0]`, and `host_be_n[3:2]` is ignored. The byte count is the number of active lanes, and the active lanes must be contiguous.
- R3: On a write, the bytes of the active lanes, lowest lane first, are appended to the stream. They are stored at consecutive buffer addresses starting at the pointer, for any start alignment.
- R4: On a read, the next bytes of the stream are returned in the active lanes, lowest lane first. Inactive lanes read as zero.
- R5: An access with no active lane completes in its first cycle and moves no byte.
- R6: A write stalls while the outbound queue count plus the requested count exceeds 12. The count is taken before this cycle's drain.
- R7: A read stalls while the inbound queue holds fewer bytes than requested.
- R8: A pulse on `ptr_we` captures `ptr_val` and `ptr_rd`, where 1 means read direction. All host accesses with a nonzero count stall while the load is pending. Queued outbound bytes drain at the old pointer first. The load then empties the inbound queue. In write direction no read-ahead takes place.
- R9: The memory side moves at most one byte per clock. Draining outbound bytes takes priority over read-ahead, and the pointer advances by one for each byte moved.
- R10: In read direction, read-ahead fills the inbound queue to twelve bytes and never past that. The pointer therefore ends twelve bytes beyond the last byte the host has taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Host access request, held until accepted |
| host_we | input | 1 | 1 = write access, 0 = read access |
| host_a1 | input | 1 | Address bit 1, selects the upper word for 16-bit hosts |
| host_be_n | input | 4 | Active-low byte enables |
| host_wdata | input | 32 | Write data lanes |
| host_rdata | output | 32 | Read data lanes, zero in inactive lanes |
| host_rdy | output | 1 | Access completes at the clock edge where sel and rdy are high |
| ptr_we | input | 1 | Load pulse for the buffer pointer |
| ptr_rd | input | 1 | Direction for the load: 1 read, 0 write |
| ptr_val | input | AW | New pointer value |

## Verification
The embedded properties watch on every cycle that neither queue overflows or underflows. They check that the pointer steps by exactly one per byte moved and holds otherwise, that a load installs the captured address, and that host byte enables stay contiguous. Byte ordering across mixed widths and alignments, the stall counts under back-to-back dword writes and after a read-direction load, the flushing of stale read-ahead, and the twelve-byte read-ahead distance can be shown only by the bench's scenarios. These scenarios compare data that went through the buffer against a model of the stream.

// File: rtl/hdp_pkg.sv
`timescale 1ns/1ps
package hdp_pkg;
    localparam int LANES = 4;
    localparam int NBW   = 3;

    typedef logic [LANES-1:0] lane_mask_t;

    typedef enum logic {
        DIR_WR = 1'b0,
        DIR_RD = 1'b1
    } dir_e;
endpackage

// File: rtl/hdp_lane_dec.sv
`timescale 1ns/1ps
module hdp_lane_dec
    import hdp_pkg::*;
(
    input  logic             a1,
    input  logic [LANES-1:0] be_n,
    output lane_mask_t       mask,
    output logic [NBW-1:0]   nbytes,
    output logic [1:0]       first
);
    always_comb begin
        if (a1) mask = {~be_n[1:0], 2'b00};
        else    mask = ~be_n;
        nbytes = '0;
        first  = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (mask[i]) first = 2'(i);
        end
        for (int i = 0; i < LANES; i++) begin
            nbytes = nbytes + NBW'(mask[i]);
        end
    end
endmodule

// File: rtl/hdp_byte_fifo.sv
`timescale 1ns/1ps
module hdp_byte_fifo
    import hdp_pkg::*;
#(
    parameter int DEPTH = 12,
    parameter int PUSHW = 4,
    parameter int POPW  = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic [NBW-1:0]     push_n,
    input  logic [PUSHW*8-1:0] push_data,
    input  logic [NBW-1:0]     pop_n,
    output logic [POPW*8-1:0]  win,
    output logic [$clog2(DEPTH+1)-1:0] cnt
);
    localparam int IW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        logic [IW-1:0]         head;
        logic [CW-1:0]         cnt;
    } fifo_t;

    fifo_t st_d, st_q;

    function automatic logic [IW-1:0] wrap(input int a);
        return IW'(a % DEPTH);
    endfunction

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.cnt = '0;
        end else begin
            for (int i = 0; i < PUSHW; i++) begin
                if (i < int'(push_n)) begin
                    st_d.mem[wrap(int'(st_q.head) + int'(st_q.cnt) + i)] = push_data[i*8 +: 8];
                end
            end
            st_d.head = wrap(int'(st_q.head) + int'(pop_n));
            st_d.cnt  = CW'(int'(st_q.cnt) + int'(push_n) - int'(pop_n));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    generate
        for (genvar g = 0; g < POPW; g++) begin : g_win
            assign win[g*8 +: 8] = st_q.mem[wrap(int'(st_q.head) + g)];
        end
    endgenerate

    assign cnt = st_q.cnt;

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |-> (int'(st_q.cnt) + int'(push_n) - int'(pop_n) <= DEPTH));

    // R7
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |-> (int'(pop_n) <= int'(st_q.cnt)));

    // R10
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.cnt) <= DEPTH);
endmodule

// File: rtl/hdp_mem_seq.sv
`timescale 1ns/1ps
module hdp_mem_seq
    import hdp_pkg::*;
#(
    parameter int DEPTH = 12,
    parameter int AW    = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ptr_we,
    input  logic          ptr_rd,
    input  logic [AW-1:0] ptr_val,
    input  logic [$clog2(DEPTH+1)-1:0] wf_cnt,
    input  logic [$clog2(DEPTH+1)-1:0] rf_cnt,
    output logic          ram_we,
    output logic [AW-1:0] ram_addr,
    output logic          wf_pop,
    output logic          rf_push,
    output logic          rf_flush,
    output logic          pend
);
    typedef struct packed {
        logic [AW-1:0] ptr;
        dir_e          dir;
        logic          pend;
        logic [AW-1:0] pend_ptr;
        dir_e          pend_dir;
        logic          infl;
    } seq_t;

    seq_t s_d, s_q;
    logic rd_issue;

    always_comb begin
        s_d      = s_q;
        ram_we   = 1'b0;
        ram_addr = s_q.ptr;
        wf_pop   = 1'b0;
        rd_issue = 1'b0;
        rf_flush = 1'b0;
        rf_push  = s_q.infl;
        s_d.infl = 1'b0;
        if (s_q.pend && wf_cnt == '0) begin
            s_d.ptr  = s_q.pend_ptr;
            s_d.dir  = s_q.pend_dir;
            s_d.pend = 1'b0;
            rf_flush = 1'b1;
            rf_push  = 1'b0;
        end else if (wf_cnt != '0) begin
            ram_we  = 1'b1;
            wf_pop  = 1'b1;
            s_d.ptr = s_q.ptr + AW'(1);
        end else if (!s_q.pend && s_q.dir == DIR_RD &&
                     (int'(rf_cnt) + int'(s_q.infl) < DEPTH)) begin
            rd_issue = 1'b1;
            s_d.ptr  = s_q.ptr + AW'(1);
            s_d.infl = 1'b1;
        end
        if (ptr_we) begin
            s_d.pend     = 1'b1;
            s_d.pend_ptr = ptr_val;
            s_d.pend_dir = ptr_rd ? DIR_RD : DIR_WR;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pend = s_q.pend;

    // R9
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we || rd_issue) |=> (s_q.ptr == $past(s_q.ptr) + AW'(1)));

    // R9
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ram_we && !rd_issue && !rf_flush) |=> $stable(s_q.ptr));

    // R8
    ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_flush |=> (s_q.ptr == $past(s_q.pend_ptr)));

    // R9
    one_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({ram_we, rd_issue, rf_flush}) <= 1);
endmodule

// File: rtl/hdp_buf_ram.sv
`timescale 1ns/1ps
module hdp_buf_ram #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    localparam int WORDS = 1 << AW;

    logic [7:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        rdata <= mem[addr];
    end
endmodule

// File: rtl/hdp_port.sv
`timescale 1ns/1ps
module hdp_port
    import hdp_pkg::*;
#(
    parameter int DEPTH = 12,
    parameter int AW    = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_sel,
    input  logic          host_we,
    input  logic          host_a1,
    input  logic [3:0]    host_be_n,
    input  logic [31:0]   host_wdata,
    output logic [31:0]   host_rdata,
    output logic          host_rdy,
    input  logic          ptr_we,
    input  logic          ptr_rd,
    input  logic [AW-1:0] ptr_val
);
    localparam int CW = $clog2(DEPTH + 1);

    lane_mask_t     mask;
    logic [NBW-1:0] nbytes;
    logic [1:0]     first;

    logic [CW-1:0]  wf_cnt, rf_cnt;
    logic [NBW-1:0] wf_push_n, rf_pop_n;
    logic [31:0]    wf_push_data;
    logic [7:0]     wf_head;
    logic [31:0]    rf_win;
    logic           ram_we, wf_pop, rf_push, rf_flush, pend;
    logic [AW-1:0]  ram_addr;
    logic [7:0]     ram_rdata;

    hdp_lane_dec u_dec (
        .a1     (host_a1),
        .be_n   (host_be_n),
        .mask   (mask),
        .nbytes (nbytes),
        .first  (first)
    );

    always_comb begin
        if (!host_sel)          host_rdy = 1'b0;
        else if (nbytes == '0)  host_rdy = 1'b1;
        else if (pend)          host_rdy = 1'b0;
        else if (host_we)       host_rdy = (int'(wf_cnt) + int'(nbytes) <= DEPTH);
        else                    host_rdy = (int'(rf_cnt) >= int'(nbytes));
    end

    assign wf_push_n = (host_sel && host_we && host_rdy)  ? nbytes : '0;
    assign rf_pop_n  = (host_sel && !host_we && host_rdy) ? nbytes : '0;

    always_comb begin
        wf_push_data = '0;
        for (int j = 0; j < LANES; j++) begin
            if (int'(first) + j < LANES) begin
                wf_push_data[j*8 +: 8] = host_wdata[(int'(first) + j)*8 +: 8];
            end
        end
    end

    always_comb begin
        host_rdata = '0;
        for (int l = 0; l < LANES; l++) begin
            if (mask[l] && l >= int'(first)) begin
                host_rdata[l*8 +: 8] = rf_win[(l - int'(first))*8 +: 8];
            end
        end
    end

    hdp_byte_fifo #(.DEPTH(DEPTH), .PUSHW(LANES), .POPW(1)) u_wfifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (1'b0),
        .push_n    (wf_push_n),
        .push_data (wf_push_data),
        .pop_n     ({{(NBW-1){1'b0}}, wf_pop}),
        .win       (wf_head),
        .cnt       (wf_cnt)
    );

    hdp_byte_fifo #(.DEPTH(DEPTH), .PUSHW(1), .POPW(LANES)) u_rfifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (rf_flush),
        .push_n    ({{(NBW-1){1'b0}}, rf_push}),
        .push_data (ram_rdata),
        .pop_n     (rf_pop_n),
        .win       (rf_win),
        .cnt       (rf_cnt)
    );

    hdp_mem_seq #(.DEPTH(DEPTH), .AW(AW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ptr_we   (ptr_we),
        .ptr_rd   (ptr_rd),
        .ptr_val  (ptr_val),
        .wf_cnt   (wf_cnt),
        .rf_cnt   (rf_cnt),
        .ram_we   (ram_we),
        .ram_addr (ram_addr),
        .wf_pop   (wf_pop),
        .rf_push  (rf_push),
        .rf_flush (rf_flush),
        .pend     (pend)
    );

    hdp_buf_ram #(.AW(AW)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (wf_head),
        .rdata (ram_rdata)
    );

    // R2
    lane_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_sel |-> (mask == 4'b0000 || mask == 4'b0001 || mask == 4'b0010 ||
                      mask == 4'b0100 || mask == 4'b1000 || mask == 4'b0011 ||
                      mask == 4'b0110 || mask == 4'b1100 || mask == 4'b0111 ||
                      mask == 4'b1110 || mask == 4'b1111));

    // R8
    pend_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && ram_we) |=> ($past(ram_addr) + AW'(1) == ram_addr) || !ram_we);
endmodule

// File: tb/tb_hdp_port.sv
`timescale 1ns/1ps
module tb_hdp_port;
    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          host_sel, host_we, host_a1;
    logic [3:0]    host_be_n;
    logic [31:0]   host_wdata, host_rdata;
    logic          host_rdy;
    logic          ptr_we, ptr_rd;
    logic [AW-1:0] ptr_val;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] model [1 << AW];

    always #5 clk = ~clk;

    hdp_port #(.DEPTH(12), .AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_we(host_we),
        .host_a1(host_a1), .host_be_n(host_be_n), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_rdy(host_rdy), .ptr_we(ptr_we),
        .ptr_rd(ptr_rd), .ptr_val(ptr_val)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // pattern k -> {a1, be_n}
    function automatic logic [4:0] pat(input int k);
        case (k)
            0: return {1'b0, 4'b0000};
            1: return {1'b0, 4'b1100};
            2: return {1'b0, 4'b0011};
            3: return {1'b0, 4'b1110};
            4: return {1'b0, 4'b1101};
            5: return {1'b0, 4'b1011};
            6: return {1'b0, 4'b0111};
            7: return {1'b1, 4'b1100};
            8: return {1'b1, 4'b1110};
            9: return {1'b1, 4'b1101};
            10: return {1'b0, 4'b1001};
            default: return {1'b0, 4'b1000};
        endcase
    endfunction

    function automatic logic [3:0] lanes_of(input logic [4:0] p);
        return p[4] ? {~p[1:0], 2'b00} : ~p[3:0];
    endfunction

    function automatic int cnt_of(input logic [3:0] m);
        return int'(m[0]) + int'(m[1]) + int'(m[2]) + int'(m[3]);
    endfunction

    function automatic int first_of(input logic [3:0] m);
        for (int i = 0; i < 4; i++) if (m[i]) return i;
        return 0;
    endfunction

    function automatic logic [7:0] sv_byte(input int s, input int i);
        return 8'(i * 37 + s * 11 + 5);
    endfunction

    task automatic acc(input logic we, input logic [4:0] p, input logic [31:0] wd,
                       output logic [31:0] rd, output int stalls);
        host_sel   = 1'b1;
        host_we    = we;
        host_a1    = p[4];
        host_be_n  = p[3:0];
        host_wdata = wd;
        stalls     = 0;
        #1;
        while (!host_rdy && stalls < 500) begin
            stalls++;
            @(negedge clk);
            #1;
        end
        rd = host_rdata;
        @(negedge clk);
        host_sel = 1'b0;
    endtask

    task automatic ptr_load(input int addr, input logic rd);
        ptr_we  = 1'b1;
        ptr_val = AW'(addr);
        ptr_rd  = rd;
        @(negedge clk);
        ptr_we  = 1'b0;
    endtask

    task automatic wr_stream(input int base, input int total, input int s);
        int done = 0;
        for (int k = 0; done < total; k++) begin
            logic [4:0]  p = pat((k + s) % 12);
            logic [3:0]  m = lanes_of(p);
            int          n = cnt_of(m);
            int          f = first_of(m);
            logic [31:0] wd = 32'hEEEE_EEEE;
            logic [31:0] rd;
            int          st;
            for (int j = 0; j < n; j++) begin
                wd[(f + j)*8 +: 8] = sv_byte(s, done + j);
                model[base + done + j] = sv_byte(s, done + j);
            end
            acc(1'b1, p, wd, rd, st);
            done += n;
        end
    endtask

    task automatic rd_stream(input int base, input int total, input int s);
        int done = 0;
        for (int k = 0; done < total; k++) begin
            logic [4:0]  p = pat((k * 5 + s + 3) % 12);
            logic [3:0]  m;
            int          n, f, st;
            logic [31:0] exp = '0;
            logic [31:0] rd;
            if (done + cnt_of(lanes_of(p)) > total) p = pat(3);
            m = lanes_of(p);
            n = cnt_of(m);
            f = first_of(m);
            for (int j = 0; j < n; j++) exp[(f + j)*8 +: 8] = model[base + done + j];
            acc(1'b0, p, 32'h0, rd, st);
            chk("R2 R3 R4 stream order", rd, exp);
            done += n;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int st;
        int stv [4];
        rst_n = 1'b0; host_sel = 1'b0; host_we = 1'b0; host_a1 = 1'b0;
        host_be_n = 4'hF; host_wdata = '0; ptr_we = 1'b0; ptr_rd = 1'b0; ptr_val = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state seen at the ports
        #1 chk("R1 rdy idle", 32'(host_rdy), 32'd0);
        host_sel = 1'b1; host_we = 1'b0; host_be_n = 4'b0000;
        #1 chk("R1 read stalls", 32'(host_rdy), 32'd0);
        host_we = 1'b1;
        #1 chk("R1 write ready", 32'(host_rdy), 32'd1);
        host_sel = 1'b0;
        repeat (20) @(negedge clk);
        host_sel = 1'b1; host_we = 1'b0; host_be_n = 4'b1110;
        #1 chk("R1 R8 no read-ahead in write dir", 32'(host_rdy), 32'd0);
        host_sel = 1'b0;
        @(negedge clk);

        // R6: back-to-back dword writes, fourth stalls two cycles
        ptr_load(700, 1'b0);
        repeat (3) @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            logic [31:0] wd;
            for (int j = 0; j < 4; j++) begin
                wd[j*8 +: 8] = sv_byte(7, k*4 + j);
                model[700 + k*4 + j] = sv_byte(7, k*4 + j);
            end
            acc(1'b1, pat(0), wd, rd, stv[k]);
        end
        chk("R6 first write", 32'(stv[0]), 32'd0);
        chk("R6 third write", 32'(stv[2]), 32'd0);
        chk("R6 fourth write stalls", 32'(stv[3]), 32'd2);

        // R2 R3 R4 R8 R9: sweep over start alignment and mixed widths
        for (int s = 0; s < 4; s++) begin
            int base = 100 * s + s;
            ptr_load(base, 1'b0);
            wr_stream(base, 44, s);
            ptr_load(base, 1'b1);
            rd_stream(base, 40, s);
        end

        // R7: dword read right after a read-direction load stalls six cycles
        ptr_load(101, 1'b1);
        acc(1'b0, pat(0), 32'h0, rd, st);
        chk("R7 read stall count", 32'(st), 32'd6);
        chk("R7 read data", rd, {model[104], model[103], model[102], model[101]});

        // R5: empty access completes at once and consumes nothing
        acc(1'b0, {1'b0, 4'b1111}, 32'h0, rd, st);
        chk("R5 zero mask no stall", 32'(st), 32'd0);
        chk("R5 zero mask data", rd, 32'h0);
        acc(1'b0, pat(3), 32'h0, rd, st);
        chk("R5 next byte kept", rd, {24'h0, model[105]});

        // R8: reload discards stale read-ahead
        ptr_load(202, 1'b1);
        acc(1'b0, pat(4), 32'h0, rd, st);
        chk("R8 first region byte", rd, {16'h0, model[202], 8'h0});
        ptr_load(303, 1'b1);
        acc(1'b0, pat(0), 32'h0, rd, st);
        chk("R8 flush after reload", rd, {model[306], model[305], model[304], model[303]});

        // R10 R9: read-ahead stops twelve bytes out; a write lands there
        ptr_load(700, 1'b1);
        repeat (30) @(negedge clk);
        acc(1'b1, pat(3), 32'h0000_00AB, rd, st);
        model[712] = 8'hAB;
        repeat (5) @(negedge clk);
        ptr_load(712, 1'b1);
        acc(1'b0, pat(3), 32'h0, rd, st);
        chk("R10 read-ahead distance", rd, 32'h0000_00AB);
        acc(1'b0, pat(11), 32'h0, rd, st);
        chk("R9 following bytes", rd, {8'h0, model[715], model[714], model[713]});

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule